// File: doc/BRIEF.md
# Host Data-Path Byte Ordering Unit

This unit joins a 16-bit host bus to a 32-bit internal data path. Every host access is classed into one of four paths: a data FIFO reached through a low address window, a data FIFO reached through a dedicated select input, a status FIFO, or a control/status register. The unit then reorders the bytes of the 32-bit word to suit that path. Two reorderings are available. One exchanges the two 16-bit halves (word swap). The other reverses all four bytes (big-endian conversion).

Writes arrive as two 16-bit host accesses, lower half first. The unit packs them into one 32-bit word and hands that word to an internal sink with a one-cycle strobe. Reads fetch one 32-bit word from an internal source on the lower-half access, return the lower half, and keep the upper half for the following access. The two data FIFO paths each have their own endianness bit. Register and status traffic ignores both bits and only follows the word swap. For writes the swap stage comes before the endian stage; for reads the order is reversed.

Top module: `hbo_order_unit`

## Requirements
- R1: Path code (0 register, 1 data FIFO by window, 2 data FIFO by select, 3 status FIFO) is chosen as follows. An asserted `host_fifo_sel` gives code 2 whatever the address. Otherwise, byte addresses 00h to 3Fh (32-bit words 00h to 3Ch) give code 1. Addresses 40h to 4Fh give code 3. Every other address gives code 0.
- R2: On path 1, `cfg_port_be`=0 leaves the byte order unchanged, and `cfg_port_be`=1 reverses the four bytes (byte 3 becomes byte 0, byte 2 becomes byte 1, and so on).
- R3: On path 2, `cfg_sel_be` controls the byte reversal in the same way.
- R4: On paths 0 and 3, both endianness bits have no effect and the order is little endian.
- R5: The word swap exchanges bits 31:16 with bits 15:0 on every path. It is active only when `cfg_swap_ctl` is all ones. Any other value, including a partial pattern, gives no swap.
- R6: A write access with address bit 1 = 0 holds the 16-bit data as the lower half. A write access with bit 1 = 1 supplies the upper half and completes the word. One cycle later, `wr_valid` is high for exactly one cycle, with `wr_data` = endian(swap({upper, lower})) and `wr_path` set to the path of the completing access.
- R7: A read access with address bit 1 = 0 raises `rd_req` in the same cycle, with `rd_path`, and samples `src_rdata`. The next cycle, `host_rdata` shows bits 15:0 of swap(endian(src)). A read with bit 1 = 1 shows the held bits 31:16 the next cycle. `host_rdata` stays unchanged while no read access is made.
- R8: After reset, `host_rdata` is 0, `wr_valid` is 0, and the held lower half is 0.
- R9: A word written through one path and configuration, then stored by the sink and read back through the same path and configuration, returns the original host word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs | input | 1 | Host access in this cycle |
| host_we | input | 1 | 1 write, 0 read |
| host_addr | input | ADDR_W | Host byte address |
| host_fifo_sel | input | 1 | Dedicated data FIFO select |
| host_wdata | input | 16 | Host write half-word |
| host_rdata | output | 16 | Host read half-word (registered) |
| cfg_port_be | input | 1 | Big endian for the window FIFO path |
| cfg_sel_be | input | 1 | Big endian for the select FIFO path |
| cfg_swap_ctl | input | 32 | Word swap control value |
| wr_valid | output | 1 | Internal write strobe |
| wr_path | output | 2 | Path code of the write |
| wr_data | output | 32 | Reordered write word |
| rd_req | output | 1 | Internal read fetch strobe |
| rd_path | output | 2 | Path code of the fetch |
| src_rdata | input | 32 | Word from the internal source |

## Verification
The bench builds the unit with its default parameters: an 8-bit address, the window FIFO ending at 3Fh, and the status window at 40h to 4Fh. With these values every path, including the edge words 3Ch and 40h, is reachable by a small set of addresses. The bench walks all eight combinations of the two endianness bits and the swap enable on each of the four paths, for both writes and reads. Each written word is fed back as read source data, which proves round-trip consistency. A partial swap control value shows that only the all-ones value enables the swap.

// File: rtl/hbo_pkg.sv
package hbo_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    P_REG  = 2'd0,
    P_PORT = 2'd1,
    P_SEL  = 2'd2,
    P_STAT = 2'd3
  } path_e;

  function automatic logic [WORD_W-1:0] halves_swap(input logic [WORD_W-1:0] w);
    return {w[HALF_W-1:0], w[WORD_W-1:HALF_W]};
  endfunction

  function automatic logic [WORD_W-1:0] bytes_rev(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < WORD_W/8; b++)
      r[b*8 +: 8] = w[(WORD_W/8-1-b)*8 +: 8];
    return r;
  endfunction

  function automatic logic path_big(input path_e p, input logic port_be, input logic sel_be);
    case (p)
      P_PORT:  return port_be;
      P_SEL:   return sel_be;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/hbo_path_decode.sv
module hbo_path_decode
  import hbo_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PORT_HI  = 8'h3F,
  parameter int STAT_LO  = 8'h40,
  parameter int STAT_HI  = 8'h4F
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              fifo_sel,
  output path_e             path
);
  localparam int AW_EXT = (ADDR_W < 32) ? 32 : ADDR_W;

  logic [AW_EXT-1:0] a_ext;
  logic              in_port;
  logic              in_stat;

  assign a_ext   = AW_EXT'(addr);
  assign in_port = (a_ext <= AW_EXT'(PORT_HI));
  assign in_stat = (a_ext >= AW_EXT'(STAT_LO)) && (a_ext <= AW_EXT'(STAT_HI));

  always_comb begin
    if (fifo_sel)     path = P_SEL;
    else if (in_port) path = P_PORT;
    else if (in_stat) path = P_STAT;
    else              path = P_REG;
  end
endmodule

// File: rtl/hbo_write_pack.sv
module hbo_write_pack
  import hbo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic              upper,
  input  logic [HALF_W-1:0] wdata,
  input  path_e             path,
  input  logic              port_be,
  input  logic              sel_be,
  input  logic              swap_on,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_data,
  output path_e             wr_path
);
  logic [HALF_W-1:0] lo_q;
  logic [WORD_W-1:0] joined;
  logic [WORD_W-1:0] after_swap;
  logic [WORD_W-1:0] after_endian;
  logic              complete;

  assign complete     = acc_wr && upper;
  assign joined       = {wdata, lo_q};
  assign after_swap   = swap_on ? halves_swap(joined) : joined;
  assign after_endian = path_big(path, port_be, sel_be) ? bytes_rev(after_swap) : after_swap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
      wr_path  <= P_REG;
    end else begin
      wr_valid <= complete;
      if (acc_wr && !upper) lo_q <= wdata;
      if (complete) begin
        wr_data <= after_endian;
        wr_path <= path;
      end
    end
  end

  AST_WR_AFTER_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(acc_wr && upper)); // R6

  AST_WR_EXEMPT_LE: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && (path == P_REG || path == P_STAT) && !swap_on)
      |=> wr_data[WORD_W-1:HALF_W] == $past(wdata)); // R4
endmodule

// File: rtl/hbo_read_split.sv
module hbo_read_split
  import hbo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic              upper,
  input  path_e             path,
  input  logic              port_be,
  input  logic              sel_be,
  input  logic              swap_on,
  input  logic [WORD_W-1:0] src_rdata,
  output logic              rd_req,
  output logic [HALF_W-1:0] rdata
);
  logic [HALF_W-1:0] hi_q;
  logic [WORD_W-1:0] after_endian;
  logic [WORD_W-1:0] after_swap;

  assign rd_req       = acc_rd && !upper;
  assign after_endian = path_big(path, port_be, sel_be) ? bytes_rev(src_rdata) : src_rdata;
  assign after_swap   = swap_on ? halves_swap(after_endian) : after_endian;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      rdata <= '0;
    end else if (rd_req) begin
      rdata <= after_swap[HALF_W-1:0];
      hi_q  <= after_swap[WORD_W-1:HALF_W];
    end else if (acc_rd && upper) begin
      rdata <= hi_q;
    end
  end

  AST_RD_EXEMPT_LE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (path == P_REG || path == P_STAT) && !swap_on)
      |=> rdata == $past(src_rdata[HALF_W-1:0])); // R4

  AST_RD_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> $stable(rdata)); // R7
endmodule

// File: rtl/hbo_order_unit.sv
module hbo_order_unit
  import hbo_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PORT_HI = 8'h3F,
  parameter int STAT_LO = 8'h40,
  parameter int STAT_HI = 8'h4F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_fifo_sel,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic              cfg_port_be,
  input  logic              cfg_sel_be,
  input  logic [31:0]       cfg_swap_ctl,
  output logic              wr_valid,
  output logic [1:0]        wr_path,
  output logic [31:0]       wr_data,
  output logic              rd_req,
  output logic [1:0]        rd_path,
  input  logic [31:0]       src_rdata
);
  path_e acc_path;
  path_e wr_path_e;
  logic  swap_on;
  logic  acc_wr;
  logic  acc_rd;
  logic  upper;

  assign swap_on = (cfg_swap_ctl == '1);
  assign acc_wr  = host_cs && host_we;
  assign acc_rd  = host_cs && !host_we;
  assign upper   = host_addr[1];
  assign wr_path = wr_path_e;
  assign rd_path = acc_path;

  hbo_path_decode #(
    .ADDR_W (ADDR_W),
    .PORT_HI(PORT_HI),
    .STAT_LO(STAT_LO),
    .STAT_HI(STAT_HI)
  ) u_decode (
    .addr    (host_addr),
    .fifo_sel(host_fifo_sel),
    .path    (acc_path)
  );

  hbo_write_pack u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_wr  (acc_wr),
    .upper   (upper),
    .wdata   (host_wdata),
    .path    (acc_path),
    .port_be (cfg_port_be),
    .sel_be  (cfg_sel_be),
    .swap_on (swap_on),
    .wr_valid(wr_valid),
    .wr_data (wr_data),
    .wr_path (wr_path_e)
  );

  hbo_read_split u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_rd   (acc_rd),
    .upper    (upper),
    .path     (acc_path),
    .port_be  (cfg_port_be),
    .sel_be   (cfg_sel_be),
    .swap_on  (swap_on),
    .src_rdata(src_rdata),
    .rd_req   (rd_req),
    .rdata    (host_rdata)
  );

  AST_SEL_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && upper && host_fifo_sel) |=> wr_path == 2'd2); // R1

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !$past(acc_wr && upper)) |-> 1'b0); // R6

  AST_FETCH_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (host_cs && !host_we && !host_addr[1])); // R7
endmodule

// File: tb/hbo_order_unit_tb.sv
module hbo_order_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_cs = 1'b0, host_we = 1'b0, host_fifo_sel = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        cfg_port_be = 1'b0, cfg_sel_be = 1'b0;
  logic [31:0] cfg_swap_ctl = '0;
  logic        wr_valid, rd_req;
  logic [1:0]  wr_path, rd_path;
  logic [31:0] wr_data;
  logic [31:0] src_rdata = '0;

  int  n_run = 0, n_fail = 0;
  bit  exp_wv = 1'b0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  hbo_order_unit dut_i (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_fifo_sel(host_fifo_sel), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cfg_port_be(cfg_port_be), .cfg_sel_be(cfg_sel_be),
    .cfg_swap_ctl(cfg_swap_ctl), .wr_valid(wr_valid), .wr_path(wr_path),
    .wr_data(wr_data), .rd_req(rd_req), .rd_path(rd_path), .src_rdata(src_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model, byte-indexed
  function automatic int ref_path(input logic [7:0] a, input logic sel);
    if (sel) return 2;
    if (a < 8'h40) return 1;
    if (a < 8'h50) return 3;
    return 0;
  endfunction

  function automatic bit ref_big(input int p);
    if (p == 1) return cfg_port_be;
    if (p == 2) return cfg_sel_be;
    return 1'b0;
  endfunction

  function automatic logic [31:0] ref_wr(input logic [31:0] w, input bit big, input bit swp);
    logic [7:0] t [4];
    logic [31:0] o;
    for (int i = 0; i < 4; i++) t[i] = w[8*(swp ? (i ^ 2) : i) +: 8];
    for (int i = 0; i < 4; i++) o[8*i +: 8] = t[big ? 3 - i : i];
    return o;
  endfunction

  function automatic logic [31:0] ref_rd(input logic [31:0] w, input bit big, input bit swp);
    logic [7:0] t [4];
    logic [31:0] o;
    for (int i = 0; i < 4; i++) t[i] = w[8*(big ? 3 - i : i) +: 8];
    for (int i = 0; i < 4; i++) o[8*i +: 8] = t[swp ? (i ^ 2) : i];
    return o;
  endfunction

  // every-clock monitor of the write strobe
  always @(posedge clk) begin
    #3;
    if (rst_n) check("R6 strobe", {31'd0, wr_valid}, {31'd0, exp_wv});
  end

  task automatic wr32(input logic [7:0] base, input bit sel, input logic [31:0] w,
                      output logic [31:0] got);
    int p;
    p = ref_path(base | 8'h2, sel);
    @(negedge clk);
    host_cs = 1; host_we = 1; host_fifo_sel = sel; host_addr = base & 8'hFD; host_wdata = w[15:0];
    @(negedge clk);
    host_addr = base | 8'h2; host_wdata = w[31:16]; exp_wv = 1;
    @(negedge clk);
    host_cs = 0; host_fifo_sel = 0; exp_wv = 0;
    check($sformatf("R6 R%0d wr_data", p == 1 ? 2 : (p == 2 ? 3 : 4)), wr_data,
          ref_wr(w, ref_big(p), cfg_swap_ctl == 32'hFFFF_FFFF));
    check("R1 wr_path", {30'd0, wr_path}, p);
    got = wr_data;
  endtask

  task automatic rd32(input logic [7:0] base, input bit sel, input logic [31:0] src,
                      output logic [31:0] got);
    int p;
    logic [31:0] e;
    p = ref_path(base & 8'hFD, sel);
    e = ref_rd(src, ref_big(p), cfg_swap_ctl == 32'hFFFF_FFFF);
    @(negedge clk);
    host_cs = 1; host_we = 0; host_fifo_sel = sel; host_addr = base & 8'hFD; src_rdata = src;
    #1;
    check("R7 rd_req", {31'd0, rd_req}, 32'd1);
    check("R1 rd_path", {30'd0, rd_path}, p);
    @(negedge clk);
    check("R7 low half", {16'd0, host_rdata}, {16'd0, e[15:0]});
    got[15:0] = host_rdata;
    host_addr = base | 8'h2; src_rdata = ~src;
    #1;
    check("R7 no fetch on upper", {31'd0, rd_req}, 32'd0);
    @(negedge clk);
    host_cs = 0; host_fifo_sel = 0;
    check("R7 high half", {16'd0, host_rdata}, {16'd0, e[31:16]});
    got[31:16] = host_rdata;
    @(negedge clk);
    check("R7 idle hold", {16'd0, host_rdata}, {16'd0, e[31:16]});
  endtask

  initial begin
    logic [7:0]  bases [4];
    bit          sels  [4];
    logic [31:0] w, stored, back;
    bases[0] = 8'h54; sels[0] = 0;   // register
    bases[1] = 8'h20; sels[1] = 0;   // window FIFO
    bases[2] = 8'h84; sels[2] = 1;   // select FIFO (address outside window)
    bases[3] = 8'h44; sels[3] = 0;   // status FIFO
    repeat (3) @(negedge clk);
    check("R8 reset rdata", {16'd0, host_rdata}, 32'd0);
    check("R8 reset wr_valid", {31'd0, wr_valid}, 32'd0);
    rst_n = 1;
    // R8: upper-only write right after reset uses a zero lower half
    @(negedge clk);
    host_cs = 1; host_we = 1; host_addr = 8'h56; host_wdata = 16'hBEEF; exp_wv = 1;
    @(negedge clk);
    host_cs = 0; exp_wv = 0;
    check("R8 cleared lower half", wr_data, 32'hBEEF_0000);

    for (int c = 0; c < 8; c++) begin
      cfg_port_be  = c[0];
      cfg_sel_be   = c[1];
      cfg_swap_ctl = c[2] ? 32'hFFFF_FFFF : 32'h0;
      for (int p = 0; p < 4; p++) begin
        w = 32'h1122_3344 ^ {c[7:0], p[7:0], 8'hA5, 8'h0F};
        wr32(bases[p], sels[p], w, stored);
        rd32(bases[p], sels[p], stored, back);
        check("R9 round trip", back, w);
        rd32(bases[p], sels[p], 32'hC0DE_0102 + c * 4 + p, back);
      end
    end

    // R5: partial swap pattern does nothing
    cfg_port_be = 0; cfg_sel_be = 0; cfg_swap_ctl = 32'hFFFF_FFFE;
    wr32(8'h54, 0, 32'hAABB_CCDD, stored);
    check("R5 partial key", stored, 32'hAABB_CCDD);
    // R1 boundaries: 3Ch word is window, 40h word is status, 50h is register
    cfg_port_be = 1; cfg_sel_be = 1; cfg_swap_ctl = 32'h0;
    wr32(8'h3C, 0, 32'h0102_0304, stored);
    check("R2 edge word", stored, 32'h0403_0201);
    wr32(8'h40, 0, 32'h0102_0304, stored);
    check("R4 status edge", stored, 32'h0102_0304);
    wr32(8'h50, 0, 32'h0102_0304, stored);
    check("R4 register edge", stored, 32'h0102_0304);
    // R3: select beats a window address
    cfg_port_be = 0;
    wr32(8'h10, 1, 32'h0102_0304, stored);
    check("R3 select over window", stored, 32'h0403_0201);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule